// File: doc/BRIEF.md
# Word-Serial AES-128 Cipher Core

This block encrypts or decrypts one 128-bit block under a 128-bit key with the AES-128 algorithm. Block data arrives as a series of narrow words on one input port, and the result leaves the same way on one output port. With the default 32-bit word, each direction takes four beats. A single runtime select chooses encryption or decryption. That select and the key are captured together with the first word of each block.

Inside, the core works on one round per clock. It keeps a single 128-bit register, which collects the input words, holds the cipher state while the rounds run, and then shifts the result out. The round keys are derived on the fly from a 128-bit key register. Encryption derives each key forward as the rounds run. Decryption first spends ten cycles walking the schedule forward to the last round key. It then steps the schedule backward, one round key per round.

The handshake is a plain valid/ready pair on each side. The core takes no new block until the previous result has been read out completely.

Top module: `aes_word_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the core returns to idle: after that edge `in_ready` is 1 and `out_valid` is 0.
- R2: A block is carried as four 32-bit words, most significant word first. Word k holds block bits [127-32k:96-32k], which is state column k. Block byte 0 (bits 127:120) is row 0, column 0, and bytes fill the state column by column. The result leaves in the same word order.
- R3: With `decrypt` = 0, the output block is the AES-128 ciphertext of the input block under `key`. Encryption runs a key addition, nine full rounds, and a final round without column mixing.
- R4: With `decrypt` = 1, the output block is the AES-128 decryption of the input block under `key`. Decryption uses the round keys in reverse order.
- R5: For any key and block, decrypting the ciphertext that the core produced gives back the original block.
- R6: `key` and `decrypt` are sampled only on the accepted beat that carries word 0. Changing them during words 1 to 3 has no effect on the result.
- R7: From the edge that accepts word 3 until the edge that delivers the last output word, `in_ready` stays 0, and any `in_valid` beat offered in that interval is ignored. `in_ready` returns to 1 once the last output word has been taken.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_word` does not change.
- R9: For encryption, `out_valid` rises exactly 10 clock edges after the edge that accepts word 3.
- R10: For decryption, `out_valid` rises exactly 20 clock edges after the edge that accepts word 3. Ten of these edges pre-compute the last round key.
- R11: `in_ready` and `out_valid` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| decrypt | input | 1 | 0 = encrypt, 1 = decrypt; sampled with word 0 |
| key | input | 128 | Cipher key; sampled with word 0 |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Core can accept an input word |
| in_word | input | WORD_W (32) | Input block word |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer takes the output word |
| out_word | output | WORD_W (32) | Result block word |

## Verification
The bench builds the core with its default WORD_W of 32. That gives four beats per block in each direction, so every word position of both the input shifter and the output shifter is exercised on every transfer.

Published AES-128 answer vectors pin down the byte and word ordering and both cipher directions. On top of these, a sweep sends each of the 128 single-bit plaintexts through an encrypt-then-decrypt round trip. Each sweep step uses a different arithmetically derived key, so every state bit position passes through both datapaths.

The bench also holds off the consumer while a result is pending and offers input words during that time. It changes the key and the select during words 1 to 3 of a block. It counts edges from the acceptance of the last input word until the result appears, in both directions.

// File: rtl/aes_pkg.sv
`timescale 1ns/1ps
// aes_pkg: shared GF(2^8) arithmetic, S-box functions and the state type
// for the word-serial AES-128 core. The S-boxes are computed (inversion
// plus affine map), so no table is stored.
package aes_pkg;

    typedef enum logic [1:0] {ST_LOAD, ST_EXPAND, ST_ROUND, ST_DRAIN} core_st_t;

    // Multiply by x modulo x^8+x^4+x^3+x+1.
    function automatic logic [7:0] gf_x2(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // General GF(2^8) product by shift-and-add.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p;
        logic [7:0] t;
        p = 8'h00;
        t = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ t;
            t = gf_x2(t);
        end
        return p;
    endfunction

    // Multiplicative inverse as a^254; zero maps to zero.
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        logic [7:0] base;
        logic [7:0] e;
        r    = 8'h01;
        base = a;
        e    = 8'hfe;
        for (int i = 0; i < 8; i++) begin
            if (e[i]) r = gf_mul(r, base);
            base = gf_mul(base, base);
        end
        return r;
    endfunction

    // Forward substitution: inversion, then affine map with constant 63.
    function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
        logic [7:0] v;
        v = gf_inv(a);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

    // Inverse substitution: inverse affine map with constant 05, then inversion.
    function automatic logic [7:0] sbox_inv(input logic [7:0] a);
        logic [7:0] t;
        t = {a[1:0], a[7:2]} ^ {a[4:0], a[7:5]} ^ {a[6:0], a[7]} ^ 8'h05;
        return gf_inv(t);
    endfunction

    // Round constant for key-schedule step n (1..10).
    function automatic logic [7:0] rcon_of(input logic [3:0] n);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 1; i < 10; i++) begin
            if (i < int'(n)) r = gf_x2(r);
        end
        return r;
    endfunction

    // Rotate a key word by one byte, substitute each byte, add the constant.
    function automatic logic [31:0] key_mix_word(input logic [31:0] w, input logic [7:0] rc);
        logic [31:0] rot;
        rot = {w[23:0], w[31:24]};
        return {sbox_fwd(rot[31:24]) ^ rc, sbox_fwd(rot[23:16]),
                sbox_fwd(rot[15:8]), sbox_fwd(rot[7:0])};
    endfunction

    // Column mixing (inv=0) or its inverse (inv=1) on one 4-byte column.
    function automatic logic [31:0] mix_col(input logic [31:0] col, input logic inv);
        logic [31:0] m;
        logic [31:0] o;
        logic [7:0]  acc;
        m = inv ? 32'h0e0b0d09 : 32'h02030101;
        o = 32'h0;
        for (int r = 0; r < 4; r++) begin
            acc = 8'h00;
            for (int j = 0; j < 4; j++) begin
                acc = acc ^ gf_mul(m[31 - 8 * ((j - r + 4) % 4) -: 8], col[31 - 8 * j -: 8]);
            end
            o[31 - 8 * r -: 8] = acc;
        end
        return o;
    endfunction

endpackage

// File: rtl/aes_key_step.sv
`timescale 1ns/1ps
// aes_key_step: one step of the AES-128 key schedule in both directions.
// key_fwd is the round key that follows key_cur; key_bwd is the one before it.
// Assumes rcon is the constant of the step that links key_cur to the neighbour
// being computed.
module aes_key_step
    import aes_pkg::*;
(
    input  logic [127:0] key_cur,
    input  logic [7:0]   rcon,
    output logic [127:0] key_fwd,
    output logic [127:0] key_bwd
);
    logic [31:0] w0, w1, w2, w3;
    logic [31:0] f0, f1, f2, f3;
    logic [31:0] p0, p1, p2, p3;

    assign {w0, w1, w2, w3} = key_cur;

    // Forward step: each word chains on the word computed before it.
    always_comb begin
        f0 = w0 ^ key_mix_word(w3, rcon);
        f1 = w1 ^ f0;
        f2 = w2 ^ f1;
        f3 = w3 ^ f2;
        key_fwd = {f0, f1, f2, f3};
    end

    // Backward step: undo the chain from the top word down.
    always_comb begin
        p3 = w3 ^ w2;
        p2 = w2 ^ w1;
        p1 = w1 ^ w0;
        p0 = w0 ^ key_mix_word(p3, rcon);
        key_bwd = {p0, p1, p2, p3};
    end
endmodule

// File: rtl/aes_round_unit.sv
`timescale 1ns/1ps
// aes_round_unit: one combinational AES round on the 128-bit state.
// Encrypt: substitute, rotate rows left, mix columns (skipped when last),
// add key. Decrypt: rotate rows right, inverse substitute, add key, inverse
// mix (skipped when last). The state byte order is column-major: byte 4c+r
// sits at bits [127-8(4c+r) -: 8].
module aes_round_unit
    import aes_pkg::*;
(
    input  logic [127:0] st_in,
    input  logic [127:0] rkey,
    input  logic         decrypt,
    input  logic         last,
    output logic [127:0] st_out
);
    logic [127:0] sub_q;
    logic [127:0] mix_e;
    logic [127:0] key_d;
    logic [127:0] mix_d;

    // Row rotation folded into the byte routing feeding each S-box.
    for (genvar c = 0; c < 4; c++) begin : g_col
        for (genvar r = 0; r < 4; r++) begin : g_row
            localparam int DST   = 4 * c + r;
            localparam int SRC_E = 4 * ((c + r) % 4) + r;
            localparam int SRC_D = 4 * ((c + 4 - r) % 4) + r;
            assign sub_q[127 - 8 * DST -: 8] = decrypt ? sbox_inv(st_in[127 - 8 * SRC_D -: 8])
                                                       : sbox_fwd(st_in[127 - 8 * SRC_E -: 8]);
        end
        assign mix_e[127 - 32 * c -: 32] = mix_col(sub_q[127 - 32 * c -: 32], 1'b0);
        assign mix_d[127 - 32 * c -: 32] = mix_col(key_d[127 - 32 * c -: 32], 1'b1);
    end

    assign key_d = sub_q ^ rkey;

    // Pick the ordering of key addition and mixing for the direction.
    always_comb begin
        if (decrypt) st_out = last ? key_d : mix_d;
        else         st_out = (last ? sub_q : mix_e) ^ rkey;
    end
endmodule

// File: rtl/aes_word_core.sv
`timescale 1ns/1ps
// aes_word_core: iterative AES-128 engine with word-serial block ports.
// One 128-bit register collects the input words, holds the state through
// the rounds and shifts the result out. Round keys are made on the fly;
// decryption first walks the schedule forward to the last round key.
// Assumes WORD_W divides 128 and is smaller than 128.
module aes_word_core
    import aes_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              decrypt,
    input  logic [127:0]      key,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word
);
    localparam int BLK_W  = 128;
    localparam int BEATS  = BLK_W / WORD_W;
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
    localparam logic [3:0] NR = 4'd10;

    core_st_t          st;
    logic [BEAT_W-1:0] beat;
    logic [3:0]        rnd;
    logic              dec_q;
    logic [127:0]      key_q;
    logic [127:0]      data_q;
    logic [127:0]      blk_next;
    logic [127:0]      key_fwd;
    logic [127:0]      key_bwd;
    logic [127:0]      round_out;
    logic [7:0]        rcon;
    logic              backward;

    assign in_ready  = (st == ST_LOAD);
    assign out_valid = (st == ST_DRAIN);
    assign out_word  = data_q[BLK_W-1 -: WORD_W];
    assign blk_next  = {data_q[BLK_W-1-WORD_W:0], in_word};
    assign backward  = dec_q && (st == ST_ROUND);

    // Step constant: forward uses the current round, backward the next one.
    assign rcon = rcon_of(backward ? 4'(rnd + 4'd1) : rnd);

    aes_key_step u_key (
        .key_cur (key_q),
        .rcon    (rcon),
        .key_fwd (key_fwd),
        .key_bwd (key_bwd)
    );

    aes_round_unit u_round (
        .st_in   (data_q),
        .rkey    (dec_q ? key_bwd : key_fwd),
        .decrypt (dec_q),
        .last    (dec_q ? (rnd == 4'd0) : (rnd == NR)),
        .st_out  (round_out)
    );

    // Sequencer: load beats, optional key walk, rounds, then drain beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_LOAD;
            beat   <= '0;
            rnd    <= '0;
            dec_q  <= 1'b0;
            key_q  <= '0;
            data_q <= '0;
        end else begin
            case (st)
                ST_LOAD: if (in_valid) begin
                    if (beat == '0) begin
                        key_q <= key;
                        dec_q <= decrypt;
                    end
                    if (beat == LAST_BEAT) begin
                        beat <= '0;
                        rnd  <= 4'd1;
                        if (dec_q) begin
                            data_q <= blk_next;
                            st     <= ST_EXPAND;
                        end else begin
                            data_q <= blk_next ^ key_q;
                            st     <= ST_ROUND;
                        end
                    end else begin
                        beat   <= beat + BEAT_W'(1);
                        data_q <= blk_next;
                    end
                end
                ST_EXPAND: begin
                    key_q <= key_fwd;
                    if (rnd == NR) begin
                        data_q <= data_q ^ key_fwd;
                        rnd    <= NR - 4'd1;
                        st     <= ST_ROUND;
                    end else begin
                        rnd <= rnd + 4'd1;
                    end
                end
                ST_ROUND: begin
                    data_q <= round_out;
                    key_q  <= dec_q ? key_bwd : key_fwd;
                    if (dec_q) begin
                        if (rnd == 4'd0) st <= ST_DRAIN;
                        else             rnd <= rnd - 4'd1;
                    end else begin
                        if (rnd == NR) st <= ST_DRAIN;
                        else           rnd <= rnd + 4'd1;
                    end
                end
                ST_DRAIN: if (out_ready) begin
                    data_q <= data_q << WORD_W;
                    if (beat == LAST_BEAT) begin
                        beat <= '0;
                        st   <= ST_LOAD;
                    end else begin
                        beat <= beat + BEAT_W'(1);
                    end
                end
                default: st <= ST_LOAD;
            endcase
        end
    end

    // R11: the two port directions never overlap.
    assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R8: a stalled output word is held.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    // R7: closing the input leaves at least one busy cycle before any result.
    assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |=> !out_valid);

    // R7: input reopens exactly when the result has been drained.
    assert_reopen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> in_ready);

    // R9: encryption round index stays inside its ten rounds.
    assert_round_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ROUND && !dec_q) |-> (rnd >= 4'd1 && rnd <= NR));
endmodule

// File: tb/tb_aes_word_core.sv
`timescale 1ns/1ps
// tb_aes_word_core: known-answer vectors, a single-bit round-trip sweep,
// stall, sampling and latency checks.
module tb_aes_word_core;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         decrypt = 1'b0;
    logic [127:0] key = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_word = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [W-1:0] out_word;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    aes_word_core #(.WORD_W(W)) dut (
        .clk, .rst_n, .decrypt, .key, .in_valid, .in_ready, .in_word,
        .out_valid, .out_ready, .out_word
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Send one block; with scr set, key and select change after word 0.
    task automatic send(input logic [127:0] blk, input logic [127:0] k, input bit dec, input bit scr);
        bit acc;
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b1;
            in_word  = blk[127 - 32 * i -: 32];
            if (i == 0 || !scr) begin
                key     = k;
                decrypt = dec;
            end else begin
                key     = ~k ^ {4{32'(i)}};
                decrypt = ~dec;
            end
            do begin
                acc = in_ready;
                @(negedge clk);
            end while (!acc);
        end
        in_valid = 1'b0;
    endtask

    // Collect one result and the edge count until out_valid appears.
    task automatic recv(output logic [127:0] res, output int lat);
        lat = 0;
        out_ready = 1'b1;
        while (!out_valid) begin
            @(negedge clk);
            lat++;
        end
        for (int i = 0; i < 4; i++) begin
            while (!out_valid) @(negedge clk);
            res[127 - 32 * i -: 32] = out_word;
            @(negedge clk);
        end
    endtask

    task automatic run(input logic [127:0] blk, input logic [127:0] k, input bit dec,
                       input bit scr, output logic [127:0] res, output int lat);
        send(blk, k, dec, scr);
        recv(res, lat);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] res;
        logic [127:0] res2;
        logic [127:0] k1;
        logic [127:0] k2;
        logic [127:0] kz;
        logic [127:0] p1;
        logic [127:0] p2;
        logic [127:0] p3;
        logic [127:0] c1;
        logic [127:0] c2;
        logic [127:0] c3;
        logic [127:0] cz;
        logic [W-1:0] held;
        int lat;

        k1 = 128'h000102030405060708090a0b0c0d0e0f;
        p1 = 128'h00112233445566778899aabbccddeeff;
        c1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
        k2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
        p2 = 128'h3243f6a8885a308d313198a2e0370734;
        c2 = 128'h3925841d02dc09fbdc118597196a0b32;
        p3 = 128'h6bc1bee22e409f96e93d7e117393172a;
        c3 = 128'h3ad77bb40d7a3660a89ecaf32466ef97;
        kz = '0;
        cz = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(in_ready == 1'b1, "R1 in_ready after reset", 128'(in_ready), 128'd1);
        check(out_valid == 1'b0, "R1 out_valid after reset", 128'(out_valid), 128'd0);

        // R2, R3, R9: known answers for encryption.
        run(p1, k1, 1'b0, 1'b0, res, lat);
        check(res == c1, "R3 R2 encrypt vector 1", res, c1);
        check(lat == 10, "R9 encrypt latency", 128'(lat), 128'd10);
        run(p2, k2, 1'b0, 1'b0, res, lat);
        check(res == c2, "R3 encrypt vector 2", res, c2);
        run(p3, k2, 1'b0, 1'b0, res, lat);
        check(res == c3, "R3 encrypt vector 3", res, c3);
        run('0, kz, 1'b0, 1'b0, res, lat);
        check(res == cz, "R3 encrypt zero key", res, cz);

        // R4, R10: known answers for decryption.
        run(c1, k1, 1'b1, 1'b0, res, lat);
        check(res == p1, "R4 R2 decrypt vector 1", res, p1);
        check(lat == 20, "R10 decrypt latency", 128'(lat), 128'd20);
        run(c2, k2, 1'b1, 1'b0, res, lat);
        check(res == p2, "R4 decrypt vector 2", res, p2);
        run(c3, k2, 1'b1, 1'b0, res, lat);
        check(res == p3, "R4 decrypt vector 3", res, p3);
        run(cz, kz, 1'b1, 1'b0, res, lat);
        check(res == '0, "R4 decrypt zero key", res, 128'h0);

        // R6: key and select changed after word 0 are ignored.
        run(p2, k2, 1'b0, 1'b1, res, lat);
        check(res == c2, "R6 encrypt with late key change", res, c2);
        run(c1, k1, 1'b1, 1'b1, res, lat);
        check(res == p1, "R6 decrypt with late select change", res, p1);

        // R7, R8, R11: hold off the consumer and offer input meanwhile.
        send(p1, k1, 1'b0, 1'b0);
        out_ready = 1'b0;
        while (!out_valid) @(negedge clk);
        held = out_word;
        in_valid = 1'b1;
        in_word  = 32'hdeadbeef;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(out_valid == 1'b1, "R8 out_valid held", 128'(out_valid), 128'd1);
            check(out_word == held, "R8 out_word stable", 128'(out_word), 128'(held));
            check(in_ready == 1'b0, "R7 R11 in_ready low while pending", 128'(in_ready), 128'd0);
        end
        in_valid = 1'b0;
        recv(res, lat);
        check(res == c1, "R7 result after stall and ignored input", res, c1);
        check(in_ready == 1'b1, "R7 in_ready back after drain", 128'(in_ready), 128'd1);
        run(p2, k2, 1'b0, 1'b0, res, lat);
        check(res == c2, "R7 next block unaffected", res, c2);

        // R5, R9, R10: single-bit plaintext sweep, round trip each.
        for (int i = 0; i < 128; i++) begin
            logic [127:0] pt;
            logic [127:0] kk;
            pt = 128'd1 << i;
            kk = {32'(i) * 32'h9e3779b9, 32'(i + 7) * 32'h85ebca6b,
                  ~(32'(i) * 32'hc2b2ae35), 32'(i) ^ 32'h27d4eb2f};
            run(pt, kk, 1'b0, 1'b0, res, lat);
            check(lat == 10, "R9 sweep encrypt latency", 128'(lat), 128'd10);
            run(res, kk, 1'b1, 1'b0, res2, lat);
            check(lat == 20, "R10 sweep decrypt latency", 128'(lat), 128'd20);
            check(res2 == pt, "R5 round trip", res2, pt);
        end

        // R1: reset in mid-computation returns to idle.
        send(p1, k1, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(in_ready == 1'b1, "R1 in_ready after mid-run reset", 128'(in_ready), 128'd1);
        check(out_valid == 1'b0, "R1 out_valid after mid-run reset", 128'(out_valid), 128'd0);
        run(p1, k1, 1'b0, 1'b0, res, lat);
        check(res == c1, "R1 operation after mid-run reset", res, c1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule